// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block builds the word that a flash array returns when software reads the bank that is busy with an embedded program or erase. It does not run the program or erase algorithms. It takes their state as inputs: the operation kind, bit 7 of the word being programmed, whether the addressed sector is being erased or is suspended, a timeout flag and an erase-window flag. From these it forms a polling bit, two toggle bits, a timeout bit and an erase-timer bit. It also drives an active-low ready/busy output.

The toggle bits are flops that advance once for each accepted read strobe. They do not advance on the clock. So software that reads twice in a row can tell from a changed bit that work is still going on. A pulse on `op_start_i` clears both toggles. Reads that do not return status pass the array data through unchanged. This covers a bank that is not busy, an idle operation, or a sector that is not suspended during erase-suspend.

Top module: `flash_wstat_gen`

## Requirements
- R1: After reset, and on every `op_start_i` pulse, both toggle bits are 0. The first status read after that returns 0 in bit 6 and in bit 2, and `op_start_i` takes priority over a simultaneous read strobe.
- R2: When `bank_busy_i` is 0, or `op_kind_i` is idle (2'b00), `rd_data_o` equals `array_i`.
- R3: While programming (`op_kind_i` = 2'b01) on the busy bank, bit 7 reads the inverse of `prog_bit_i`. Bits 4, 1, 0 and all bits from 8 upward read 0.
- R4: While erasing (`op_kind_i` = 2'b10) on the busy bank, bit 7 reads 0.
- R5: During program or erase, bit 6 inverts after each status read. Idle clock cycles without a read strobe leave it unchanged.
- R6: In erase-suspend (`op_kind_i` = 2'b11), a read of a sector with `sec_susp_i` = 1 returns bit 7 = 1, and bit 6 keeps its value across reads.
- R7: Bit 2 inverts after each status read of a sector with `sec_erasing_i` = 1 during erase, or with `sec_susp_i` = 1 during erase-suspend. In every other status read, including all program reads, it holds.
- R8: Bit 5 equals `tmo_i` during program and erase status reads, and reads 0 in erase-suspend status reads.
- R9: During erase, bit 3 reads 0 while `ewin_i` = 1 and reads 1 while `ewin_i` = 0. During program and erase-suspend it reads 0.
- R10: `ryby_no` is 0 during program and erase, and 1 when idle or in erase-suspend.
- R11: A read strobe that passes array data through (R2, or a sector that is not suspended during erase-suspend) advances neither toggle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_start_i | input | 1 | Pulse at the start of an embedded operation; clears the toggles |
| op_kind_i | input | 2 | 00 idle, 01 program, 10 erase, 11 erase-suspend |
| bank_busy_i | input | 1 | The read targets the bank running the operation |
| sec_erasing_i | input | 1 | Addressed sector is selected for erase |
| sec_susp_i | input | 1 | Addressed sector is erase-suspended |
| prog_bit_i | input | 1 | Bit 7 of the word being programmed |
| tmo_i | input | 1 | Operation exceeded its time limit |
| ewin_i | input | 1 | Erase window open; more sector-erase commands are accepted |
| rd_stb_i | input | 1 | One-cycle read strobe |
| array_i | input | DW | Array data for the addressed location |
| rd_data_o | output | DW | Status word or array data |
| ryby_no | output | 1 | Ready/busy, low while busy |

## Verification
Program reads are run with both values of the programmed bit, with and without a timeout, and with long idle gaps between reads. These show that bit 7 is inverted and that bit 6 follows reads rather than clocks. Erase reads switch the erasing-sector and erase-window flags. This separates the bit 2 toggle from bit 6 and shows how bit 3 follows the window. Reads of a non-busy bank and of a non-suspended sector are placed between status reads. The status read that follows reveals whether a toggle moved when it should not have. Suspend reads and a restart in the middle of a sequence show that bit 6 freezes while bit 2 keeps toggling, and that a start clears both toggles.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_SUSP  = 2'b11
  } op_kind_e;

  // bit positions decoded by polling software
  localparam int unsigned BIT_POLL = 7;
  localparam int unsigned BIT_TOG  = 6;
  localparam int unsigned BIT_TMO  = 5;
  localparam int unsigned BIT_ETMR = 3;
  localparam int unsigned BIT_STOG = 2;
  localparam int unsigned MIN_DW   = 8;
endpackage

// File: rtl/fws_toggle.sv
module fws_toggle #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= RST_VAL;
    else if (clr_i) q_q <= RST_VAL;
    else if (adv_i) q_q <= ~q_q;
  end

  assign q_o = q_q;

  a_r1_clear_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == RST_VAL));
  a_r5_adv_flips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i) |=> (q_o != $past(q_o)));
  a_r11_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/fws_decode.sv
module fws_decode
  import flash_wstat_pkg::*;
(
  input  op_kind_e kind_i,
  input  logic     bank_busy_i,
  input  logic     sec_erasing_i,
  input  logic     sec_susp_i,
  input  logic     rd_stb_i,
  output logic     stat_sel_o,
  output logic     adv_tog_o,
  output logic     adv_stog_o,
  output logic     ryby_no
);
  logic running;
  logic susp_hit;

  always_comb begin
    running    = (kind_i == OP_PROG) || (kind_i == OP_ERASE);
    susp_hit   = (kind_i == OP_SUSP) && sec_susp_i;
    stat_sel_o = bank_busy_i && (running || susp_hit);
    adv_tog_o  = rd_stb_i && bank_busy_i && running;
    adv_stog_o = rd_stb_i && bank_busy_i &&
                 (((kind_i == OP_ERASE) && sec_erasing_i) || susp_hit);
    ryby_no    = !running;
  end
endmodule

// File: rtl/fws_compose.sv
module fws_compose
  import flash_wstat_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          stat_sel_i,
  input  op_kind_e      kind_i,
  input  logic          prog_bit_i,
  input  logic          tmo_i,
  input  logic          ewin_i,
  input  logic          tog_i,
  input  logic          stog_i,
  input  logic [DW-1:0] array_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] stat_w;

  always_comb begin
    stat_w = '0;
    unique case (kind_i)
      OP_PROG: begin
        stat_w[BIT_POLL] = ~prog_bit_i;
        stat_w[BIT_TOG]  = tog_i;
        stat_w[BIT_TMO]  = tmo_i;
        stat_w[BIT_STOG] = stog_i;
      end
      OP_ERASE: begin
        stat_w[BIT_TOG]  = tog_i;
        stat_w[BIT_TMO]  = tmo_i;
        stat_w[BIT_ETMR] = ~ewin_i;
        stat_w[BIT_STOG] = stog_i;
      end
      OP_SUSP: begin
        stat_w[BIT_POLL] = 1'b1;
        stat_w[BIT_TOG]  = tog_i;
        stat_w[BIT_STOG] = stog_i;
      end
      default: stat_w = '0;
    endcase
    rd_data_o = stat_sel_i ? stat_w : array_i;
  end
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
  import flash_wstat_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_start_i,
  input  logic [1:0]    op_kind_i,
  input  logic          bank_busy_i,
  input  logic          sec_erasing_i,
  input  logic          sec_susp_i,
  input  logic          prog_bit_i,
  input  logic          tmo_i,
  input  logic          ewin_i,
  input  logic          rd_stb_i,
  input  logic [DW-1:0] array_i,
  output logic [DW-1:0] rd_data_o,
  output logic          ryby_no
);
  localparam int unsigned NTOG = 2;

  op_kind_e        kind;
  logic            stat_sel;
  logic [NTOG-1:0] adv;
  logic [NTOG-1:0] tog_q;

  assign kind = op_kind_e'(op_kind_i);

  fws_decode u_decode (
    .kind_i       (kind),
    .bank_busy_i  (bank_busy_i),
    .sec_erasing_i(sec_erasing_i),
    .sec_susp_i   (sec_susp_i),
    .rd_stb_i     (rd_stb_i),
    .stat_sel_o   (stat_sel),
    .adv_tog_o    (adv[0]),
    .adv_stog_o   (adv[1]),
    .ryby_no      (ryby_no)
  );

  // index 0: operation toggle, index 1: sector toggle
  for (genvar g = 0; g < NTOG; g++) begin : g_tog
    fws_toggle #(.RST_VAL(1'b0)) u_tog (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (op_start_i),
      .adv_i (adv[g]),
      .q_o   (tog_q[g])
    );
  end

  fws_compose #(.DW(DW)) u_compose (
    .stat_sel_i(stat_sel),
    .kind_i    (kind),
    .prog_bit_i(prog_bit_i),
    .tmo_i     (tmo_i),
    .ewin_i    (ewin_i),
    .tog_i     (tog_q[0]),
    .stog_i    (tog_q[1]),
    .array_i   (array_i),
    .rd_data_o (rd_data_o)
  );

  initial begin
    if (DW < MIN_DW) $error("DW below status width");
  end

  a_r2_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_busy_i |-> (rd_data_o == array_i));
  a_r6_susp_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == OP_SUSP && bank_busy_i && sec_susp_i) |-> (rd_data_o[BIT_POLL] && ryby_no));
  a_r10_busy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == OP_PROG || kind == OP_ERASE) |-> !ryby_no);
  a_r6_susp_tog_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == OP_SUSP && !op_start_i) |=> $stable(rd_data_o[BIT_TOG]) || !$stable(kind)
      || !$stable(bank_busy_i) || !$stable(sec_susp_i) || !stat_sel);
endmodule

// File: tb/tb_flash_wstat_gen.sv
module tb_flash_wstat_gen;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          op_start_i = 1'b0;
  logic [1:0]    op_kind_i = 2'b00;
  logic          bank_busy_i = 1'b1;
  logic          sec_erasing_i = 1'b0;
  logic          sec_susp_i = 1'b0;
  logic          prog_bit_i = 1'b0;
  logic          tmo_i = 1'b0;
  logic          ewin_i = 1'b0;
  logic          rd_stb_i = 1'b0;
  logic [DW-1:0] array_i = 16'hA55A;
  logic [DW-1:0] rd_data_o;
  logic          ryby_no;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic e6, e2;

  always #2 clk = ~clk;

  flash_wstat_gen #(.DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_start_i(op_start_i), .op_kind_i(op_kind_i),
    .bank_busy_i(bank_busy_i), .sec_erasing_i(sec_erasing_i), .sec_susp_i(sec_susp_i),
    .prog_bit_i(prog_bit_i), .tmo_i(tmo_i), .ewin_i(ewin_i), .rd_stb_i(rd_stb_i),
    .array_i(array_i), .rd_data_o(rd_data_o), .ryby_no(ryby_no)
  );

  function automatic logic [DW-1:0] sw(logic p7, logic t6, logic t5, logic e3, logic s2);
    logic [DW-1:0] w = '0;
    w[7] = p7; w[6] = t6; w[5] = t5; w[3] = e3; w[2] = s2;
    return w;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(output logic [DW-1:0] w);
    @(negedge clk); rd_stb_i = 1'b1;
    #1 w = rd_data_o;
    @(negedge clk); rd_stb_i = 1'b0;
  endtask

  task automatic start_op(logic [1:0] k);
    @(negedge clk); op_kind_i = k; op_start_i = 1'b1;
    @(negedge clk); op_start_i = 1'b0;
    e6 = 0; e2 = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] w;
    #1;
    chk("R2 idle passthrough", rd_data_o, array_i);
    chk("R10 idle ready", {15'd0, ryby_no}, 16'd1);
    rd(w);
    chk("R2 idle read", w, 16'hA55A);
  endtask

  task automatic t_program();
    logic [DW-1:0] w;
    start_op(2'b01);
    prog_bit_i = 1'b1; array_i = 16'hFFFF;
    #1 chk("R10 program busy", {15'd0, ryby_no}, 16'd0);
    rd(w); chk("R1 R3 first program read", w, sw(0, e6, 0, 0, e2)); e6 = ~e6;
    rd(w); chk("R5 program toggle", w, sw(0, e6, 0, 0, e2)); e6 = ~e6;
    repeat (10) @(negedge clk);
    rd(w); chk("R5 no clock advance", w, sw(0, e6, 0, 0, e2)); e6 = ~e6;
    prog_bit_i = 1'b0; tmo_i = 1'b1;
    rd(w); chk("R3 R8 inverted bit, timeout", w, sw(1, e6, 1, 0, e2)); e6 = ~e6;
    sec_erasing_i = 1'b1;
    rd(w); chk("R7 program holds bit2", w, sw(1, e6, 1, 0, e2)); e6 = ~e6;
    tmo_i = 1'b0; sec_erasing_i = 1'b0;
  endtask

  task automatic t_erase();
    logic [DW-1:0] w;
    start_op(2'b10);
    sec_erasing_i = 1'b1; ewin_i = 1'b1;
    #1 chk("R10 erase busy", {15'd0, ryby_no}, 16'd0);
    rd(w); chk("R4 R9 window open", w, sw(0, e6, 0, 0, e2)); e6 = ~e6; e2 = ~e2;
    rd(w); chk("R7 erase bit2 toggles", w, sw(0, e6, 0, 0, e2)); e6 = ~e6; e2 = ~e2;
    ewin_i = 1'b0;
    rd(w); chk("R9 erase started", w, sw(0, e6, 0, 1, e2)); e6 = ~e6; e2 = ~e2;
    sec_erasing_i = 1'b0;
    rd(w); chk("R7 other sector holds bit2", w, sw(0, e6, 0, 1, e2)); e6 = ~e6;
    tmo_i = 1'b1;
    rd(w); chk("R8 erase timeout", w, sw(0, e6, 1, 1, e2)); e6 = ~e6;
    tmo_i = 1'b0;
    bank_busy_i = 1'b0; array_i = 16'h1234;
    rd(w); chk("R2 non-busy bank", w, 16'h1234);
    bank_busy_i = 1'b1;
    rd(w); chk("R11 non-busy read no advance", w, sw(0, e6, 0, 1, e2)); e6 = ~e6;
  endtask

  task automatic t_suspend();
    logic [DW-1:0] w;
    logic f6;
    @(negedge clk); op_kind_i = 2'b11; sec_susp_i = 1'b1; tmo_i = 1'b1;
    f6 = e6;
    #1 chk("R10 suspend ready", {15'd0, ryby_no}, 16'd1);
    rd(w); chk("R6 R8 suspended sector", w, sw(1, f6, 0, 0, e2)); e2 = ~e2;
    rd(w); chk("R6 R7 bit6 frozen, bit2 toggles", w, sw(1, f6, 0, 0, e2)); e2 = ~e2;
    sec_susp_i = 1'b0; array_i = 16'h0F0F;
    rd(w); chk("R2 unsuspended sector data", w, 16'h0F0F);
    sec_susp_i = 1'b1;
    rd(w); chk("R11 unsuspended read no advance", w, sw(1, f6, 0, 0, e2)); e2 = ~e2;
    tmo_i = 1'b0; sec_susp_i = 1'b0;
  endtask

  task automatic t_restart();
    logic [DW-1:0] w;
    start_op(2'b10);
    sec_erasing_i = 1'b1; ewin_i = 1'b0;
    rd(w); e6 = ~e6; e2 = ~e2;
    // strobe coincides with start: start wins
    @(negedge clk); op_start_i = 1'b1; rd_stb_i = 1'b1;
    @(negedge clk); op_start_i = 1'b0; rd_stb_i = 1'b0;
    rd(w); chk("R1 restart clears toggles", w, sw(0, 0, 0, 1, 0));
    @(negedge clk); op_kind_i = 2'b00; sec_erasing_i = 1'b0; array_i = 16'hBEEF;
    #1 chk("R2 done shows array data", rd_data_o, 16'hBEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_program();
    t_erase();
    t_suspend();
    t_restart();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule